// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares two divided clocks, the reference pulse train and the feedback pulse train, and produces the steering commands for a charge pump in a frequency synthesiser. A rising edge on the reference input opens an "up" request. A rising edge on the feedback input opens a "down" request. Whichever request opened first is closed when the edge of the other input arrives, so the pulse width equals the phase error measured in clock cycles. An enable output tells the pump when to drive. At all other times the pump stays in its high-impedance state.

A sense input chooses the loop polarity. When it is high, the up and down commands leave on their natural pins. When it is low, the two are swapped, which suits an oscillator whose tuning slope is negative. The same input selects which divided clock appears on a monitor output. A lock indicator stays high while the loop is settled and drops during any correction pulse that lasts longer than a programmable number of cycles. Taking the power input low clears the detector, silences the pump and forces the lock indicator low.

Both pulse inputs are assumed to be synchronous to the block clock. Each input must stay low for at least one clock cycle between two rising edges.

Top module: `phase_lock_detector`

## Requirements
- R1: A rising edge on `fr_i` (the input was low at the previous clock edge and is high now) starts an up request from that clock edge on, provided no down request is pending. A rising edge on `fp_i` starts a down request in the same way. The request stays active until the opposite input rises, so the pulse lasts exactly as many cycles as the gap between the two edges.
- R2: The up and down requests are never active in the same cycle. The edge that would make both active clears both at that clock edge. Rising edges on both inputs at the same clock edge produce no pulse at all.
- R3: With `sense_i` = 1, the up request appears on `pump_up_o` and the down request on `pump_dn_o`. With `sense_i` = 0, the up request appears on `pump_dn_o` and the down request on `pump_up_o`.
- R4: `mon_o` follows `fr_i` when `sense_i` = 1 and follows `fp_i` when `sense_i` = 0, whatever the power state.
- R5: `pump_en_o` is high exactly when `pump_up_o` or `pump_dn_o` is high. When it is low, the pump is in its high-impedance state.
- R6: `lock_o` is high whenever no request is active. Take a request lasting W cycles with threshold T = `lock_thresh_i`. `lock_o` is low in pulse cycles T+1 through W, which is max(0, W−T) cycles, and it returns high in the cycle the request ends.
- R7: While `pwr_on_i` = 0, `pump_up_o`, `pump_dn_o`, `pump_en_o` and `lock_o` are all low at once. Any pending request is cleared at the next clock edge. Edges that arrive during power-down start no request after power returns.
- R8: After reset with power on, `pump_up_o`, `pump_dn_o` and `pump_en_o` are low and `lock_o` is high.
- R9: With T = 0, `lock_o` is low for every cycle of a request. The internal width count saturates at its maximum instead of wrapping. With T at its maximum of 255 and a pulse of 300 cycles, `lock_o` is low for exactly 45 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fr_i | input | 1 | Divided reference pulse train |
| fp_i | input | 1 | Divided feedback pulse train |
| sense_i | input | 1 | Loop polarity: 1 normal, 0 swapped; also selects the monitor source |
| pwr_on_i | input | 1 | 1 for normal operation, 0 for power-down |
| lock_thresh_i | input | TW (8) | Pulse length in cycles that is still counted as locked |
| pump_up_o | output | 1 | Charge-pump source command |
| pump_dn_o | output | 1 | Charge-pump sink command |
| pump_en_o | output | 1 | Pump drive enable; low means high impedance |
| lock_o | output | 1 | Lock indicator, high when settled |
| mon_o | output | 1 | Monitor of the selected divided clock |

## Verification
The hardest state to reach from the ports is a correction pulse long enough to drive the width counter into saturation. This needs an edge gap longer than the counter can represent, together with the largest threshold. The stimulus holds back the feedback edge for 300 cycles with a threshold of 255 and counts the low cycles of `lock_o`. A counter that wrapped would raise the indicator again partway through the pulse and give the wrong count. A second hard case is a power-down that lands in the middle of an open request. The bench opens an up request, drops power partway through it, and checks that the request is gone once power returns.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency detector.
// Assumes: none; pure type definitions.
package pfd_pkg;

    // Pair of internal requests before polarity selection.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // Meaning of the sense input level.
    typedef enum logic {
        SENSE_SWAP = 1'b0,
        SENSE_NORM = 1'b1
    } sense_e;

endpackage

// File: rtl/pfd_edge_det.sv
// Rising-edge detector for CH synchronous level inputs.
// Assumes: inputs are synchronous to clk; each output pulses for one cycle
// while an input is high and was low at the previous edge.
module pfd_edge_det #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] lvl_i,
    output logic [CH-1:0] rise_o
);

    for (genvar g = 0; g < CH; g++) begin : g_ch
        logic prev_q;

        // Remember the level seen at the last clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl_i[g];
        end

        assign rise_o[g] = lvl_i[g] & ~prev_q;
    end

endmodule

// File: rtl/pfd_flops.sv
// Two-state detector core: a reference edge opens UP, a feedback edge opens
// DOWN, and the edge that would make both active clears both at once.
// Assumes: edge strobes are one cycle wide; pd_n low holds the core cleared.
module pfd_flops
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pd_n,
    input  logic  fr_rise,
    input  logic  fp_rise,
    output pump_t state_o
);

    pump_t st_q, st_d;
    logic  up_set, dn_set;

    // Next request state, with coincidence clear and power-down hold.
    always_comb begin
        up_set = st_q.up | fr_rise;
        dn_set = st_q.dn | fp_rise;
        if (!pd_n || (up_set && dn_set)) begin
            st_d = '0;
        end else begin
            st_d.up = up_set;
            st_d.dn = dn_set;
        end
    end

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));

    p_pd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!st_q.up && !st_q.dn));

    p_up_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && fr_rise && !fp_rise && !st_q.dn) |=> st_q.up);

    p_dn_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && fp_rise && !fr_rise && !st_q.up) |=> st_q.dn);

endmodule

// File: rtl/pfd_lock_mon.sv
// Lock monitor: counts the cycles of the current request and drops the lock
// indicator once the count reaches the threshold; the count saturates.
// Assumes: active_i is the OR of the internal requests; pd_n low forces low.
module pfd_lock_mon #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_n,
    input  logic          active_i,
    input  logic [CW-1:0] thresh_i,
    output logic          lock_o
);

    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_q;
    logic          too_long;

    // Width counter: cleared when idle, saturating while active.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!active_i)       cnt_q <= '0;
        else if (cnt_q != CMAX)   cnt_q <= cnt_q + 1'b1;
    end

    // Lock decision from the count of cycles already spent in this pulse.
    always_comb begin
        too_long = active_i && (cnt_q >= thresh_i);
        lock_o   = pd_n && !too_long;
    end

    p_idle_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !active_i) |-> lock_o);

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && cnt_q == CMAX) |=> (cnt_q == CMAX || cnt_q == '0));

endmodule

// File: rtl/pfd_out_stage.sv
// Output stage: polarity swap, pump enable, power gating and monitor select.
// Assumes: raw requests come from the detector core; purely combinational.
module pfd_out_stage
    import pfd_pkg::*;
(
    input  logic  sense_i,
    input  logic  pd_n,
    input  pump_t raw_i,
    input  logic  fr_i,
    input  logic  fp_i,
    output logic  up_o,
    output logic  dn_o,
    output logic  en_o,
    output logic  mon_o
);

    sense_e sense;

    // Route requests to pins according to the sense level, gated by power.
    always_comb begin
        sense = sense_e'(sense_i);
        if (sense == SENSE_NORM) begin
            up_o = pd_n & raw_i.up;
            dn_o = pd_n & raw_i.dn;
            mon_o = fr_i;
        end else begin
            up_o = pd_n & raw_i.dn;
            dn_o = pd_n & raw_i.up;
            mon_o = fp_i;
        end
        en_o = pd_n & (raw_i.up | raw_i.dn);
    end

endmodule

// File: rtl/phase_lock_detector.sv
// Top: phase-frequency detector with polarity select, pump enable, lock
// indicator and monitor output.
// Assumes: fr_i/fp_i synchronous to clk with at least one low cycle between
// rising edges; pwr_on_i low means power-down.
module phase_lock_detector
    import pfd_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fr_i,
    input  logic          fp_i,
    input  logic          sense_i,
    input  logic          pwr_on_i,
    input  logic [TW-1:0] lock_thresh_i,
    output logic          pump_up_o,
    output logic          pump_dn_o,
    output logic          pump_en_o,
    output logic          lock_o,
    output logic          mon_o
);

    localparam int NCH = 2;

    logic [NCH-1:0] rise;
    pump_t          raw;
    logic           active;

    pfd_edge_det #(.CH(NCH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({fp_i, fr_i}),
        .rise_o (rise)
    );

    pfd_flops u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pwr_on_i),
        .fr_rise (rise[0]),
        .fp_rise (rise[1]),
        .state_o (raw)
    );

    assign active = raw.up | raw.dn;

    pfd_lock_mon #(.CW(TW)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_n     (pwr_on_i),
        .active_i (active),
        .thresh_i (lock_thresh_i),
        .lock_o   (lock_o)
    );

    pfd_out_stage u_out (
        .sense_i (sense_i),
        .pd_n    (pwr_on_i),
        .raw_i   (raw),
        .fr_i    (fr_i),
        .fp_i    (fp_i),
        .up_o    (pump_up_o),
        .dn_o    (pump_dn_o),
        .en_o    (pump_en_o),
        .mon_o   (mon_o)
    );

    p_en_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en_o == (pump_up_o || pump_dn_o));

    p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on_i |-> (!pump_en_o && !lock_o && !pump_up_o && !pump_dn_o));

    p_pin_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up_o && pump_dn_o));

endmodule

// File: tb/test_phase_lock_detector.sv
module test_phase_lock_detector;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_i = 1'b0, fp_i = 1'b0, sense_i = 1'b1, pwr_on_i = 1'b1;
    logic [7:0] lock_thresh_i = 8'd10;
    logic       pump_up_o, pump_dn_o, pump_en_o, lock_o, mon_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_lock_detector i_phase_lock_detector (
        .clk           (clk),
        .rst_n         (rst_n),
        .fr_i          (fr_i),
        .fp_i          (fp_i),
        .sense_i       (sense_i),
        .pwr_on_i      (pwr_on_i),
        .lock_thresh_i (lock_thresh_i),
        .pump_up_o     (pump_up_o),
        .pump_dn_o     (pump_dn_o),
        .pump_en_o     (pump_en_o),
        .lock_o        (lock_o),
        .mon_o         (mon_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // R8: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R8", "up", pump_up_o, 0);
        check("R8", "dn", pump_dn_o, 0);
        check("R8", "en", pump_en_o, 0);
        check("R8", "lock", lock_o, 1);
    endtask

    // Pulse with a gap of 'gap' cycles between leading and trailing edges.
    task automatic t_pulse(string req, bit fr_first, int gap, int thr, bit sense,
                           int exp_up, int exp_dn, int exp_low);
        int n_up = 0, n_dn = 0, n_en = 0, n_low = 0;
        lock_thresh_i = thr[7:0];
        sense_i = sense;
        step();
        if (fr_first) fr_i = 1'b1; else fp_i = 1'b1;
        for (int i = 0; i < gap + 2; i++) begin
            if (i == gap) begin
                if (fr_first) fp_i = 1'b1; else fr_i = 1'b1;
            end
            step();
            n_up  += pump_up_o;
            n_dn  += pump_dn_o;
            n_en  += pump_en_o;
            n_low += !lock_o;
            if (i == 0) begin
                if (fr_first) fr_i = 1'b0; else fp_i = 1'b0;
            end
            if (i == gap) begin
                fr_i = 1'b0;
                fp_i = 1'b0;
            end
        end
        check(req, "up cycles", n_up, exp_up);
        check(req, "dn cycles", n_dn, exp_dn);
        check("R5", "en cycles", n_en, exp_up + exp_dn);
        check(req, "lock low cycles", n_low, exp_low);
        check("R6", "lock after pulse", lock_o, 1);
    endtask

    // R2: simultaneous edges give no pulse
    task automatic t_coincident();
        int n = 0;
        sense_i = 1'b1;
        lock_thresh_i = 8'd0;
        step();
        fr_i = 1'b1; fp_i = 1'b1;
        step();
        n += pump_up_o + pump_dn_o + pump_en_o + !lock_o;
        fr_i = 1'b0; fp_i = 1'b0;
        step();
        n += pump_up_o + pump_dn_o + pump_en_o + !lock_o;
        check("R2", "activity on coincident edges", n, 0);
    endtask

    // R4: monitor select (under power-down to avoid opening requests)
    task automatic t_monitor();
        pwr_on_i = 1'b0;
        step();
        sense_i = 1'b1; fr_i = 1'b1; fp_i = 1'b0; #1;
        check("R4", "mon sense=1 fr=1", mon_o, 1);
        sense_i = 1'b0; #1;
        check("R4", "mon sense=0 fp=0", mon_o, 0);
        fr_i = 1'b0; fp_i = 1'b1; #1;
        check("R4", "mon sense=0 fp=1", mon_o, 1);
        sense_i = 1'b1; #1;
        check("R4", "mon sense=1 fr=0", mon_o, 0);
        fr_i = 1'b0; fp_i = 1'b0;
        step();
        pwr_on_i = 1'b1;
        step();
    endtask

    // R7: power-down mid-pulse and edges ignored while down
    task automatic t_power_down();
        sense_i = 1'b1;
        lock_thresh_i = 8'd20;
        step();
        fr_i = 1'b1;
        step();
        fr_i = 1'b0;
        step();
        check("R1", "up open before power-down", pump_up_o, 1);
        pwr_on_i = 1'b0; #1;
        check("R7", "up in power-down", pump_up_o, 0);
        check("R7", "en in power-down", pump_en_o, 0);
        check("R7", "lock in power-down", lock_o, 0);
        step();
        pwr_on_i = 1'b1; #1;
        check("R7", "up after power returns", pump_up_o, 0);
        check("R7", "lock after power returns", lock_o, 1);
        step();
        pwr_on_i = 1'b0;
        fp_i = 1'b1;
        step();
        fp_i = 1'b0;
        step();
        pwr_on_i = 1'b1;
        step();
        check("R7", "dn from edge during power-down", pump_dn_o, 0);
        check("R7", "en from edge during power-down", pump_en_o, 0);
    endtask

    initial begin
        t_reset();
        t_pulse("R1", 1'b1, 5, 10, 1'b1, 5, 0, 0);
        t_pulse("R1", 1'b0, 7, 3, 1'b1, 0, 7, 4);
        t_pulse("R3", 1'b1, 4, 2, 1'b0, 0, 4, 2);
        t_pulse("R3", 1'b0, 3, 9, 1'b0, 3, 0, 0);
        t_pulse("R6", 1'b1, 6, 6, 1'b1, 6, 0, 0);
        t_pulse("R9", 1'b1, 3, 0, 1'b1, 3, 0, 3);
        t_pulse("R9", 1'b0, 300, 255, 1'b1, 0, 300, 45);
        t_coincident();
        t_monitor();
        t_power_down();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule